// File: doc/BRIEF.md
# Bit-Level Pipelined Unsigned Array Multiplier

This block multiplies two unsigned 4-bit operands and returns the full 8-bit unsigned product. Partial products are formed with AND gates. They are reduced in shift-and-add row order by a grid of three-input full-adder cells. The grid is cut by a register after every level of full adders, so no path between two registers passes through more than one full adder. The first levels fold one partial-product row each into a carry-save pair. The remaining levels resolve the upper half of the product one bit position per level, carrying the ripple carry forward in a register.

The multiplier accepts a new operand pair on every clock cycle. Each pair is qualified by a valid strobe, and a matching strobe travels alongside the data through the pipeline. The operands are carried forward with the partial sums, so every level sees the operand bits of its own pair. Back-to-back pairs therefore never interfere. A synchronous active-high reset empties the pipeline of valid work.

Top module: `mulpipe_top`

## Requirements
- R1: When `outValid` is high, `product` equals the unsigned product of the `opA` and `opB` values of the pair that strobe belongs to, for every one of the 256 operand combinations.
- R2: A pair presented with `inValid` high is captured by a rising edge, and its result appears with `outValid` high right after the seventh rising edge, counting the capturing edge as the first.
- R3: A new pair may be presented on every cycle, and each result of a back-to-back stream matches its own pair, with no mixing between neighbours.
- R4: While `rst` is sampled high, `outValid` goes low after the next edge, pairs presented with `inValid` high are dropped, and every pair still in flight is discarded and never produces an `outValid` pulse.
- R5: Cycles with `inValid` low produce no result: `outValid` is high exactly seven edges after each accepted pair and low in every other cycle, so gaps in the input stream reappear unchanged at the output.
- R6: While `outValid` is low, `product` keeps the last value that was delivered with `outValid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid state |
| inValid | input | 1 | Qualifies the operand pair in this cycle |
| opA | input | 4 | Multiplicand, unsigned |
| opB | input | 4 | Multiplier, unsigned |
| outValid | output | 1 | Marks a finished product, seven edges after capture |
| product | output | 8 | Unsigned product of the matching pair |

## Verification
The hardest situation to reach is a reset that lands while every stage holds a different live pair, combined with fresh pairs offered during the reset cycles. The stimulus fills the pipeline with back-to-back pairs and raises reset in the middle of the stream with `inValid` still high. The bench then checks that none of the discarded pairs surfaces and that the held product is unchanged. An exhaustive back-to-back sweep also keeps seven distinct operand pairs in flight at once, which exposes any operand bit that is not skewed forward with its own partial sums.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;
  parameter int OP_W = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int CSA_LVLS = OP_W - 1;
  localparam int LAT = CSA_LVLS + OP_W;
  localparam int MAX_PROD = ((1 << OP_W) - 1) * ((1 << OP_W) - 1);

  // Contents of one pipeline register: operands skewed forward plus partial sums.
  typedef struct packed {
    logic [OP_W-1:0]   opA;
    logic [OP_W-1:0]   opB;
    logic [PROD_W-1:0] sumVec;
    logic [PROD_W-1:0] cryVec;
    logic              rippleCry;
  } stage_t;

  // Strobes from control to datapath: load enable for each register level.
  typedef struct packed {
    logic [LAT-1:0] load;
  } ctrl_t;
endpackage

// File: rtl/mulpipe_ctrl.sv
module mulpipe_ctrl
  import mulpipe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  output ctrl_t strobes,
  output logic  outValid
);
  logic [LAT-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (rst) vldPipe <= '0;
    else     vldPipe <= {vldPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strobes.load[0] = inValid & ~rst;
    for (int k = 1; k < LAT; k++) strobes.load[k] = vldPipe[k-1] & ~rst;
  end

  assign outValid = vldPipe[LAT-1];

  // R4: a sampled reset leaves no valid result behind it
  assert_reset_clears_R4: assert property (@(posedge clk) rst |=> !outValid)
    else $error("reset did not clear outValid");
endmodule

// File: rtl/mulpipe_dp.sv
module mulpipe_dp
  import mulpipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             strobes,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);
  stage_t headStage;

  always_comb begin
    headStage.opA       = opA;
    headStage.opB       = opB;
    headStage.sumVec    = {{(PROD_W-OP_W){1'b0}}, opA & {OP_W{opB[0]}}};
    headStage.cryVec    = '0;
    headStage.rippleCry = 1'b0;
  end

  for (genvar k = 1; k <= LAT; k++) begin : lvl
    stage_t prevStage;
    stage_t nextStage;
    stage_t q;

    if (k == 1) begin : g_first
      assign prevStage = headStage;
    end else begin : g_chain
      assign prevStage = lvl[k-1].q;
    end

    if (k <= CSA_LVLS) begin : g_csa
      // Carry-save level: fold partial-product row k into the pair.
      logic [PROD_W-1:0] ppRow;
      assign ppRow = {{(PROD_W-OP_W){1'b0}}, prevStage.opA & {OP_W{prevStage.opB[k]}}} << k;
      always_comb begin
        nextStage           = prevStage;
        nextStage.sumVec    = prevStage.sumVec ^ prevStage.cryVec ^ ppRow;
        nextStage.cryVec    = ((prevStage.sumVec & prevStage.cryVec) |
                               (prevStage.sumVec & ppRow) |
                               (prevStage.cryVec & ppRow)) << 1;
        nextStage.rippleCry = 1'b0;
      end

      // R1: after row k the carry bits at and below position k are zero
      assert_csa_lowcarry_R1: assert property (@(posedge clk) disable iff (rst)
        $past(strobes.load[k-1]) |-> (q.cryVec[k:0] == '0))
        else $error("carry-save level %0d left a low carry", k);
    end else begin : g_ripple
      // Ripple level: resolve one upper product bit per level.
      localparam int POS = OP_W + (k - 1 - CSA_LVLS);
      logic sBit, cBit, rIn;
      assign sBit = prevStage.sumVec[POS];
      assign cBit = prevStage.cryVec[POS];
      assign rIn  = prevStage.rippleCry;
      always_comb begin
        nextStage                = prevStage;
        nextStage.sumVec[POS]    = sBit ^ cBit ^ rIn;
        nextStage.rippleCry      = (sBit & cBit) | (sBit & rIn) | (cBit & rIn);
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.load[k-1]) q <= nextStage;
    end
  end

  assign product = lvl[LAT].q.sumVec;
endmodule

// File: rtl/mulpipe_top.sv
module mulpipe_top
  import mulpipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [PROD_W-1:0] product
);
  ctrl_t strobes;

  mulpipe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mulpipe_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

  // R1: a delivered product never exceeds the largest operand square
  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (product <= PROD_W'(MAX_PROD)))
    else $error("product out of range");

  // R2: a result only appears after the last register level was loaded
  assert_valid_from_load_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(strobes.load[LAT-1]))
    else $error("outValid without a final-level load");

  // R6: the product holds when the valid strobe drops
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(outValid) |-> $stable(product))
    else $error("product changed while idle");
endmodule

// File: tb/tb_mulpipe_top.sv
`timescale 1ns/1ps
module tb_mulpipe_top;
  localparam int LATENCY = 7;
  localparam int MAXC = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic outValid;
  logic [7:0] product;

  mulpipe_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  always #2 clk = ~clk;

  int pc = 0;
  always @(posedge clk) pc <= pc + 1;

  bit stV [MAXC];
  bit stR [MAXC];
  logic [3:0] stA [MAXC];
  logic [3:0] stB [MAXC];

  int nChecks = 0;
  int nFail = 0;
  bit haveLast = 1'b0;
  logic [7:0] lastProd = '0;
  bit finished = 1'b0;

  function automatic logic [7:0] refMul(logic [3:0] a, logic [3:0] b);
    return 8'(int'(a) * int'(b));
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, pc, act, exp);
    end
  endtask

  task automatic checkOutputs();
    int j;
    bit ev;
    j = pc - LATENCY;
    ev = 1'b0;
    if (j >= 0) begin
      ev = stV[j];
      for (int m = j; m < j + LATENCY; m++) if (stR[m]) ev = 1'b0;
    end
    if (ev) begin
      logic [7:0] expP;
      expP = refMul(stA[j], stB[j]);
      check(outValid === 1'b1, "R2 R3 valid at exact latency", int'(outValid), 1);
      check(product === expP, "R1 R3 product", int'(product), int'(expP));
      lastProd = expP;
      haveLast = 1'b1;
    end else begin
      check(outValid === 1'b0, "R4 R5 no result expected", int'(outValid), 0);
      if (haveLast)
        check(product === lastProd, "R6 product held", int'(product), int'(lastProd));
    end
  endtask

  task automatic step(bit v, logic [3:0] a, logic [3:0] b, bit r);
    @(negedge clk);
    checkOutputs();
    inValid = v; opA = a; opB = b; rst = r;
    stV[pc] = v; stA[pc] = a; stB[pc] = b; stR[pc] = r;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R4: reset state
    for (int i = 0; i < 4; i++) step(1'b0, 4'd0, 4'd0, 1'b1);
    // R4: pairs offered during reset are dropped
    step(1'b1, 4'd9, 4'd7, 1'b1);
    // R1 R3: all 256 pairs back to back
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) step(1'b1, 4'(a), 4'(b), 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 4'd0, 4'd0, 1'b0);
    // R2: isolated pair, exact latency
    step(1'b1, 4'd15, 4'd15, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 4'd3, 4'd5, 1'b0);
    // R5: random stream with bubbles
    for (int i = 0; i < 200; i++)
      step(($urandom % 10) < 6, 4'($urandom), 4'($urandom), 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 4'd0, 4'd0, 1'b0);
    // R4: reset in the middle of a full pipeline, inputs still valid
    for (int i = 0; i < 5; i++) step(1'b1, 4'(i + 10), 4'(13 - i), 1'b0);
    step(1'b1, 4'd11, 4'd11, 1'b1);
    step(1'b1, 4'd12, 4'd12, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 4'($urandom), 4'($urandom), 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 4'd1, 4'd1, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired: actual %0d expected %0d", pc, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule